// File: doc/BRIEF.md
# Surround Slot Scheduler for a Serial Audio Codec Link

This block decides, once per codec frame, which surround playback samples go into the next outgoing frame and which received samples are stored. It sits between six playback FIFOs and six capture FIFOs on one side and the serial frame shifter on the other. Neither the shifter nor the FIFO storage is part of the block.

The codec drives the block through two per-frame fields. The first is a set of active-low request bits, one per audio slot. The second is a set of valid bits from the received tag. A low request on slot 3 starts a fetch: one sample is read from every enabled playback FIFO into holding registers. The samples are then placed, in the following output frame, into exactly the slots whose request bits were low. Because the holding registers keep their contents between fetches, the codec can split one sample set across two frames (half-rate) or take it whole in one frame (full-rate).

Configuration inputs select 2, 4 or 6 channels and can swap the two members of each channel pair. Received slots whose valid bit is set are routed to the matching capture FIFO. An empty playback FIFO at fetch time yields a zero sample and raises a sticky underrun flag. The codec must keep its request and valid bits in order; no recovery is attempted.

Top module: `slot_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it: `tx_valid`, `tx_slots`, `pb_pop` and `cap_push` are all zero, and `underrun` is 0.
- R2: In a cycle with `frame_start`=1 and request bit 0 (slot 3) low, `pb_pop` equals the enabled-channel mask ANDed with the complement of `pb_empty`, in that same cycle. In every other cycle `pb_pop` is zero.
- R3: Slot vector bits 0..5 stand for slots 3, 4, 6, 7, 8 and 9, which carry channels left-front, right-front, center, left-rear, right-rear and subwoofer. In the cycle after `frame_start`, `tx_valid[i]` = (request bit i low) AND (channel i enabled). A sent slot carries its 16-bit sample in bits 19:4 and zeros in bits 3:0. An unsent slot is all zero. These outputs hold until the next `frame_start`.
- R4: A sent sample is the value fetched in the same frame when that frame fetched. Otherwise it is the value left in the holding register by the last fetch. This is what allows half-rate delivery over two frames.
- R5: `cfg_chans` encoding: 0 enables bits 0,1 (2 channels); 1 enables bits 0,1,3,4 (4 channels); 2 or 3 enables all six.
- R6: `cfg_swap` bit 0 exchanges channels 0/1, bit 1 exchanges 2/5 and bit 2 exchanges 3/4. The exchange applies to the sample placed in each slot and to the capture FIFO each received slot goes to.
- R7: A fetch from an enabled channel whose FIFO is empty stores zero for that channel and pops nothing from it. `underrun` rises in the next cycle and stays 1 until reset.
- R8: In the cycle after `frame_start`, `cap_push[c]` = `rx_valid[p]` AND (channel c enabled), where p is c's swap partner (or c itself). When pushed, `cap_data` lane c holds bits 19:4 of received slot p. At all other times `cap_push` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe: the request bits, valid bits and received slots of an input frame are ready |
| req_n | input | 6 | Active-low slot request bits (bit order as in R3) |
| rx_valid | input | 6 | Received-slot valid bits from the tag |
| rx_slots | input | 120 | Six received 20-bit slots, slot i at bits 20*i+19:20*i |
| cfg_chans | input | 2 | Channel count select |
| cfg_swap | input | 3 | Pair swap controls |
| pb_empty | input | 6 | Playback FIFO empty flags |
| pb_data | input | 96 | Head sample of each playback FIFO, 16 bits per lane |
| pb_pop | output | 6 | Playback FIFO read strobes |
| tx_slots | output | 120 | Six 20-bit slots for the next output frame |
| tx_valid | output | 6 | Tag valid bits for the next output frame |
| cap_push | output | 6 | Capture FIFO write strobes |
| cap_data | output | 96 | Capture samples, 16 bits per lane |
| underrun | output | 1 | Sticky playback underrun flag |

## Verification
Several rules are checked by the assertions on every cycle. A pop happens only on a fetch-triggering frame strobe and never from an empty FIFO. Slot contents and tag bits move only right after a strobe. Pad bits are always zero. Tag bits never name a disabled channel. The underrun flag never falls. Capture writes come only right after a strobe. Which sample ends up in which slot can only be shown by the bench's scenarios, because it depends on history held across frames. These scenarios cover half-rate splits served from the holding registers, repeated requests without a new fetch, swapped pairs and underruns.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int NCH = 6;

  function automatic logic [NCH-1:0] chan_mask(input logic [1:0] cfg);
    case (cfg)
      2'd0:    chan_mask = 6'b000011;
      2'd1:    chan_mask = 6'b011011;
      default: chan_mask = 6'b111111;
    endcase
  endfunction

  function automatic logic [2:0] pair_of(input logic [2:0] idx, input logic [2:0] sw);
    case (idx)
      3'd0:    pair_of = sw[0] ? 3'd1 : 3'd0;
      3'd1:    pair_of = sw[0] ? 3'd0 : 3'd1;
      3'd2:    pair_of = sw[1] ? 3'd5 : 3'd2;
      3'd5:    pair_of = sw[1] ? 3'd2 : 3'd5;
      3'd3:    pair_of = sw[2] ? 3'd4 : 3'd3;
      3'd4:    pair_of = sw[2] ? 3'd3 : 3'd4;
      default: pair_of = idx;
    endcase
  endfunction
endpackage

// File: rtl/sched_fetch.sv
module sched_fetch
  import slot_sched_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_fire,
  input  logic [NCH-1:0]    en_mask,
  input  logic [NCH-1:0]    pb_empty,
  input  logic [NCH*SW-1:0] pb_data,
  output logic [NCH-1:0]    pb_pop,
  output logic [NCH*SW-1:0] next_hold,
  output logic              starve,
  output logic              underrun
);
  logic [NCH*SW-1:0] hold_q;

  assign pb_pop = fetch_fire ? (en_mask & ~pb_empty) : '0;
  assign starve = fetch_fire & |(en_mask & pb_empty);

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign next_hold[c*SW +: SW] = !fetch_fire ? hold_q[c*SW +: SW] :
                                   pb_pop[c]   ? pb_data[c*SW +: SW] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      underrun <= 1'b0;
    end else begin
      hold_q <= next_hold;
      if (starve) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/sched_slot_mux.sv
module sched_slot_mux
  import slot_sched_pkg::*;
#(
  parameter int SW = 16,
  parameter int LW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NCH-1:0]    req_n,
  input  logic [NCH-1:0]    en_mask,
  input  logic [2:0]        swap,
  input  logic [NCH*SW-1:0] next_hold,
  output logic [NCH*LW-1:0] tx_slots,
  output logic [NCH-1:0]    tx_valid
);
  localparam int PAD = LW - SW;

  logic [NCH-1:0]    send;
  logic [NCH*LW-1:0] slot_d;

  assign send = ~req_n & en_mask;

  for (genvar s = 0; s < NCH; s++) begin : g_slot
    logic [2:0] src;
    assign src = pair_of(3'(s), swap);
    assign slot_d[s*LW +: LW] = send[s] ? {next_hold[src*SW +: SW], {PAD{1'b0}}} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_slots <= '0;
      tx_valid <= '0;
    end else if (frame_start) begin
      tx_slots <= slot_d;
      tx_valid <= send;
    end
  end
endmodule

// File: rtl/sched_capture.sv
module sched_capture
  import slot_sched_pkg::*;
#(
  parameter int SW = 16,
  parameter int LW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NCH-1:0]    rx_valid,
  input  logic [NCH*LW-1:0] rx_slots,
  input  logic [NCH-1:0]    en_mask,
  input  logic [2:0]        swap,
  output logic [NCH-1:0]    cap_push,
  output logic [NCH*SW-1:0] cap_data
);
  logic [NCH-1:0]    push_d;
  logic [NCH*SW-1:0] data_d;

  for (genvar c = 0; c < NCH; c++) begin : g_cap
    logic [2:0] src;
    assign src = pair_of(3'(c), swap);
    assign push_d[c] = rx_valid[src] & en_mask[c];
    assign data_d[c*SW +: SW] = rx_slots[src*LW + (LW-SW) +: SW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_push <= '0;
      cap_data <= '0;
    end else begin
      cap_push <= frame_start ? push_d : '0;
      if (frame_start) cap_data <= data_d;
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic [5:0]              req_n,
  input  logic [5:0]              rx_valid,
  input  logic [6*SLOT_W-1:0]     rx_slots,
  input  logic [1:0]              cfg_chans,
  input  logic [2:0]              cfg_swap,
  input  logic [5:0]              pb_empty,
  input  logic [6*SAMPLE_W-1:0]   pb_data,
  output logic [5:0]              pb_pop,
  output logic [6*SLOT_W-1:0]     tx_slots,
  output logic [5:0]              tx_valid,
  output logic [5:0]              cap_push,
  output logic [6*SAMPLE_W-1:0]   cap_data,
  output logic                    underrun
);
  logic [NCH-1:0]          en_mask;
  logic                    fetch_fire;
  logic                    starve;
  logic [NCH*SAMPLE_W-1:0] next_hold;

  assign en_mask    = chan_mask(cfg_chans);
  assign fetch_fire = frame_start & ~req_n[0];

  sched_fetch #(.SW(SAMPLE_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_fire(fetch_fire), .en_mask(en_mask),
    .pb_empty(pb_empty), .pb_data(pb_data), .pb_pop(pb_pop),
    .next_hold(next_hold), .starve(starve), .underrun(underrun)
  );

  sched_slot_mux #(.SW(SAMPLE_W), .LW(SLOT_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .req_n(req_n),
    .en_mask(en_mask), .swap(cfg_swap), .next_hold(next_hold),
    .tx_slots(tx_slots), .tx_valid(tx_valid)
  );

  sched_capture #(.SW(SAMPLE_W), .LW(SLOT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_valid(rx_valid),
    .rx_slots(rx_slots), .en_mask(en_mask), .swap(cfg_swap),
    .cap_push(cap_push), .cap_data(cap_data)
  );
endmodule

// File: rtl/slot_sched_checker.sv
module slot_sched_checker #(
  parameter int SW = 16,
  parameter int LW = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic            fetch_fire,
  input logic            starve,
  input logic [5:0]      en_mask,
  input logic [5:0]      pb_empty,
  input logic [5:0]      pb_pop,
  input logic [6*LW-1:0] tx_slots,
  input logic [5:0]      tx_valid,
  input logic [5:0]      cap_push,
  input logic            underrun
);
  logic [5:0] pad_dirty;
  for (genvar s = 0; s < 6; s++) begin : g_pad
    assign pad_dirty[s] = |tx_slots[s*LW +: (LW-SW)];
  end

  assert_pop_needs_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_pop != 6'd0) |-> fetch_fire);

  assert_no_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_pop & pb_empty) == 6'd0);

  assert_tx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> ($stable(tx_valid) && $stable(tx_slots)));

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_dirty == 6'd0);

  assert_tag_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> ((tx_valid & ~$past(en_mask)) == 6'd0));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  assert_underrun_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> underrun);

  assert_cap_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_push != 6'd0) |-> $past(frame_start));
endmodule

bind slot_sched slot_sched_checker #(.SW(SAMPLE_W), .LW(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fetch_fire(fetch_fire),
  .starve(starve), .en_mask(en_mask), .pb_empty(pb_empty), .pb_pop(pb_pop),
  .tx_slots(tx_slots), .tx_valid(tx_valid), .cap_push(cap_push), .underrun(underrun)
);

// File: tb/test_slot_sched.sv
`timescale 1ns/1ps
module test_slot_sched;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_start = 1'b0;
  logic [5:0]   req_n = 6'h3f;
  logic [5:0]   rx_valid = '0;
  logic [119:0] rx_slots = '0;
  logic [1:0]   cfg_chans = 2'd2;
  logic [2:0]   cfg_swap = '0;
  logic [5:0]   pb_empty = '0;
  logic [95:0]  pb_data = '0;
  logic [5:0]   pb_pop;
  logic [119:0] tx_slots;
  logic [5:0]   tx_valid;
  logic [5:0]   cap_push;
  logic [95:0]  cap_data;
  logic         underrun;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic [15:0] m_hold [6];
  bit          m_under = 1'b0;

  always #2.5 clk = ~clk;

  slot_sched i_slot_sched (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .req_n(req_n),
    .rx_valid(rx_valid), .rx_slots(rx_slots), .cfg_chans(cfg_chans),
    .cfg_swap(cfg_swap), .pb_empty(pb_empty), .pb_data(pb_data),
    .pb_pop(pb_pop), .tx_slots(tx_slots), .tx_valid(tx_valid),
    .cap_push(cap_push), .cap_data(cap_data), .underrun(underrun)
  );

  function automatic logic [5:0] b_mask(input logic [1:0] cfg);
    if (cfg == 2'd0) return 6'b000011;
    if (cfg == 2'd1) return 6'b011011;
    return 6'b111111;
  endfunction

  function automatic int b_part(input int idx, input logic [2:0] sw);
    int pairs_a [3] = '{0, 2, 3};
    int pairs_b [3] = '{1, 5, 4};
    for (int k = 0; k < 3; k++) begin
      if (sw[k] && idx == pairs_a[k]) return pairs_b[k];
      if (sw[k] && idx == pairs_b[k]) return pairs_a[k];
    end
    return idx;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [5:0] rq, input logic [5:0] rv, input logic [1:0] cfg,
                           input logic [2:0] sw, input logic [5:0] emp);
    logic [5:0]  en;
    logic [5:0]  e_pop;
    logic [5:0]  e_txv;
    logic [5:0]  e_push;
    logic [15:0] smp [6];
    logic [19:0] rxs [6];
    @(negedge clk);
    en = b_mask(cfg);
    for (int c = 0; c < 6; c++) begin
      smp[c] = 16'($urandom);
      rxs[c] = 20'($urandom);
      pb_data[c*16 +: 16]  = smp[c];
      rx_slots[c*20 +: 20] = rxs[c];
    end
    req_n = rq; rx_valid = rv; cfg_chans = cfg; cfg_swap = sw; pb_empty = emp;
    frame_start = 1'b1;
    #1;
    e_pop = !rq[0] ? (en & ~emp) : 6'd0;
    check("R2 pb_pop", 128'(pb_pop), 128'(e_pop));
    if (!rq[0]) begin
      for (int c = 0; c < 6; c++) m_hold[c] = e_pop[c] ? smp[c] : 16'd0;
      if ((en & emp) != 6'd0) m_under = 1'b1;
    end
    e_txv = ~rq & en;
    for (int c = 0; c < 6; c++) e_push[c] = rv[b_part(c, sw)] & en[c];
    @(negedge clk);
    frame_start = 1'b0;
    check("R3 R5 tx_valid", 128'(tx_valid), 128'(e_txv));
    for (int s = 0; s < 6; s++) begin
      logic [19:0] e_slot;
      e_slot = e_txv[s] ? {m_hold[b_part(s, sw)], 4'h0} : 20'd0;
      check("R4 R6 tx slot", 128'(tx_slots[s*20 +: 20]), 128'(e_slot));
    end
    check("R8 cap_push", 128'(cap_push), 128'(e_push));
    for (int c = 0; c < 6; c++)
      if (e_push[c])
        check("R8 R6 cap_data", 128'(cap_data[c*16 +: 16]), 128'(rxs[b_part(c, sw)][19:4]));
    check("R7 underrun", 128'(underrun), 128'(m_under));
    @(negedge clk);
    check("R8 cap_push idle", 128'(cap_push), 128'(0));
    check("R3 tx hold", 128'(tx_valid), 128'(e_txv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    for (int c = 0; c < 6; c++) m_hold[c] = 16'd0;
    repeat (3) @(negedge clk);
    check("R1 tx_valid reset", 128'(tx_valid), 128'(0));
    check("R1 tx_slots reset", 128'(tx_slots), 128'(0));
    check("R1 pb_pop reset", 128'(pb_pop), 128'(0));
    check("R1 cap_push reset", 128'(cap_push), 128'(0));
    check("R1 underrun reset", 128'(underrun), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx_valid after reset", 128'(tx_valid), 128'(0));
    // R4 half-rate split, 6 channels: slots 3,6,7 with fetch, then 4,8,9 from holding
    run_frame(~6'b001101, 6'b111111, 2'd2, 3'b000, 6'd0);
    run_frame(~6'b110010, 6'b000000, 2'd2, 3'b000, 6'd0);
    // repeated request without fetch resends held values
    run_frame(~6'b110010, 6'b010101, 2'd2, 3'b000, 6'd0);
    // R5 full-rate 2 channels; requests on disabled slots are dropped
    run_frame(6'b000000, 6'b111111, 2'd0, 3'b000, 6'd0);
    run_frame(6'b000000, 6'b111111, 2'd1, 3'b000, 6'd0);
    // R6 all pairs swapped
    run_frame(6'b000000, 6'b100110, 2'd2, 3'b111, 6'd0);
    // R7 underrun on an enabled channel, then sticky
    run_frame(6'b000000, 6'b000000, 2'd2, 3'b000, 6'b000100);
    run_frame(6'b111111, 6'b000000, 2'd2, 3'b000, 6'd0);
    for (int i = 0; i < 300; i++)
      run_frame(6'($urandom), 6'($urandom), 2'($urandom), 3'($urandom),
                (($urandom % 8) == 0) ? 6'($urandom) : 6'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule